// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block steers a 32-bit processor into and out of its exception handlers. Each cycle it samples single-cycle request pulses for seven exception causes (reset request, undefined instruction, software interrupt, prefetch abort, data abort, normal interrupt and fast interrupt) together with the address of the instruction in flight. When a request is accepted it issues, in that same cycle, a program-counter load to the cause's fixed vector, a link-register write carrying the return address and a saved-status write carrying the status word as it stood before entry. At the next clock edge it replaces the current status word with the entry value: the new mode, interrupts masked and the processor back in its 32-bit instruction state.

The block keeps the current status word and one saved-status register for each privileged exception mode. An exception-return command loads the program counter from a link value supplied by the datapath and restores the status word from the saved register of the current mode, which drops the masks that entry set. A plain status write port lets the datapath update the status word when neither an entry nor a return claims the cycle. Instruction decode, the register file and memory stay outside. The controller only produces their control strobes.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset the status word `cpsr` is 0x000000D3 (supervisor mode, both masks set, T clear, flags clear), and `pc_load`, `lr_we` and `spsr_we` are low while no request, return or status write is applied.
- R2: On an accepted request `pc_load` is high in the same cycle, and `pc_next` is the vector: 0x00 reset, 0x04 undefined, 0x08 software interrupt, 0x0C prefetch abort, 0x10 data abort, 0x18 IRQ, 0x1C FIQ (0x14 is never produced). `pc_next` is 0 whenever `pc_load` is low.
- R3: The target mode, reported on `lr_mode` and `spsr_mode`, is supervisor 5'b10011 for reset and software interrupt, abort 5'b10111 for both aborts, undefined 5'b11011, IRQ 5'b10010 and FIQ 5'b10001 (user is 5'b10000, system 5'b11111).
- R4: On entry `spsr_we` is high in the same cycle and `spsr_data` equals `cpsr` before entry. The value is held in the saved register of the target mode until the next entry into that mode. Both fields are 0 when `spsr_we` is low.
- R5: On entry `lr_we` is high in the same cycle and `lr_data` is `cur_pc` + 4. Both `lr_data` and `lr_mode` are 0 when `lr_we` is low.
- R6: One cycle after entry `cpsr[4:0]` holds the target mode, I (bit 7) is 1 and T (bit 5) is 0. F (bit 6) becomes 1 for reset and FIQ and is otherwise unchanged. The flags in bits 31:28 and all other bits are unchanged.
- R7: When several requests arrive together, one is accepted in the order reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt.
- R8: An IRQ request is ignored while `cpsr[7]` is 1 and an FIQ request is ignored while `cpsr[6]` is 1. An ignored request makes no output move and leaves `cpsr` unchanged.
- R9: With `ret_cmd` high and no accepted request, when the current mode is FIQ, IRQ, supervisor, abort or undefined, `pc_load` is high with `pc_next` = `ret_addr`, and the next `cpsr` is that mode's saved register. In user or system mode the command has no effect.
- R10: An accepted request takes precedence over `ret_cmd` and `sr_we` in the same cycle, and a return takes precedence over `sr_we`. Otherwise `sr_we` loads `sr_wdata` into `cpsr` at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rst | input | 1 | Reset exception request pulse |
| req_und | input | 1 | Undefined instruction request pulse |
| req_swi | input | 1 | Software interrupt request pulse |
| req_pabt | input | 1 | Prefetch abort request pulse |
| req_dabt | input | 1 | Data abort request pulse |
| req_irq | input | 1 | Normal interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| cur_pc | input | AW | Address of the trapping instruction |
| ret_cmd | input | 1 | Exception-return command |
| ret_addr | input | AW | Return target taken from the link value |
| sr_we | input | 1 | Plain status word write enable |
| sr_wdata | input | 32 | Plain status word write data |
| cpsr | output | 32 | Current status word |
| pc_load | output | 1 | Program counter load strobe |
| pc_next | output | AW | New program counter value |
| lr_we | output | 1 | Link register write strobe |
| lr_mode | output | 5 | Mode whose link register is written |
| lr_data | output | AW | Return address for the link register |
| spsr_we | output | 1 | Saved-status write strobe |
| spsr_mode | output | 5 | Mode whose saved status is written |
| spsr_data | output | 32 | Status word being saved |

## Verification
Entry and return can both be requested in one cycle, and so can a plain status write. The bench raises `ret_cmd` and `sr_we` together with an exception request and also pairs a return with a status write alone, first in directed cycles and then in a long stretch of random stimulus. Each cycle the behavioural model picks the winner from R10 and predicts the strobes and the next status word. A wrong winner shows up at once as a mismatch in `pc_next` or in the status word one cycle later. Nested entries followed by returns prove that the saved registers of different modes do not disturb each other.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef logic [4:0] mode_t;

  localparam mode_t M_USR = 5'b10000;
  localparam mode_t M_FIQ = 5'b10001;
  localparam mode_t M_IRQ = 5'b10010;
  localparam mode_t M_SVC = 5'b10011;
  localparam mode_t M_ABT = 5'b10111;
  localparam mode_t M_UND = 5'b11011;
  localparam mode_t M_SYS = 5'b11111;

  localparam int SW    = 32;  // status word width
  localparam int B_I   = 7;
  localparam int B_F   = 6;
  localparam int B_T   = 5;
  localparam int NEXC  = 7;
  localparam int NBANK = 5;
  localparam int BIW   = $clog2(NBANK);

  localparam logic [SW-1:0] CPSR_RST = 32'h0000_00D3;

  // Enum order is the acceptance priority (index 0 wins).
  typedef enum logic [2:0] {
    EX_RST  = 3'd0,
    EX_DABT = 3'd1,
    EX_FIQ  = 3'd2,
    EX_IRQ  = 3'd3,
    EX_PABT = 3'd4,
    EX_UND  = 3'd5,
    EX_SWI  = 3'd6
  } exc_e;

  function automatic mode_t target_mode(exc_e e);
    case (e)
      EX_RST, EX_SWI:   return M_SVC;
      EX_DABT, EX_PABT: return M_ABT;
      EX_FIQ:           return M_FIQ;
      EX_IRQ:           return M_IRQ;
      default:          return M_UND;
    endcase
  endfunction

  // Word slot in the vector table; slot 5 is reserved and unused.
  function automatic logic [2:0] vector_slot(exc_e e);
    case (e)
      EX_RST:  return 3'd0;
      EX_UND:  return 3'd1;
      EX_SWI:  return 3'd2;
      EX_PABT: return 3'd3;
      EX_DABT: return 3'd4;
      EX_IRQ:  return 3'd6;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic [SW-1:0] entry_status(logic [SW-1:0] s, exc_e e);
    logic [SW-1:0] r;
    r        = s;
    r[4:0]   = target_mode(e);
    r[B_I]   = 1'b1;
    r[B_T]   = 1'b0;
    if (e == EX_RST || e == EX_FIQ) r[B_F] = 1'b1;
    return r;
  endfunction

  function automatic logic has_bank(mode_t m);
    return (m == M_FIQ) || (m == M_IRQ) || (m == M_SVC) ||
           (m == M_ABT) || (m == M_UND);
  endfunction

  function automatic logic [BIW-1:0] bank_idx(mode_t m);
    case (m)
      M_FIQ:   return BIW'(0);
      M_IRQ:   return BIW'(1);
      M_SVC:   return BIW'(2);
      M_ABT:   return BIW'(3);
      M_UND:   return BIW'(4);
      default: return BIW'(NBANK);  // out of range: no bank
    endcase
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int N  = NEXC,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          mask_irq,
  input  logic          mask_fiq,
  output logic          any,
  output logic [IW-1:0] idx
);

  logic [N-1:0] eff;
  logic [N-1:0] grant;

  always_comb begin
    eff = req;
    eff[int'(EX_IRQ)] = req[int'(EX_IRQ)] & ~mask_irq;
    eff[int'(EX_FIQ)] = req[int'(EX_FIQ)] & ~mask_fiq;
  end

  always_comb begin
    grant = '0;
    any   = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (eff[i] && !any) begin
        grant[i] = 1'b1;
        any      = 1'b1;
        idx      = IW'(i);
      end
    end
  end

  // R7: never more than one cause accepted
  p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R7: a reset request always wins
  p_reset_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req[int'(EX_RST)] |-> (any && idx == IW'(EX_RST)));

  // R8: masked interrupts are never accepted
  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_irq |-> !(any && idx == IW'(EX_IRQ)));

  p_fiq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_fiq |-> !(any && idx == IW'(EX_FIQ)));

endmodule

// File: rtl/exc_spsr_bank.sv
module exc_spsr_bank
  import exc_pkg::*;
#(
  parameter int NB = NBANK,
  parameter int W  = SW,
  localparam int IW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] wsel,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] rsel,
  output logic [W-1:0]  rdata
);

  logic [W-1:0]         regs_q [NB];
  logic [NB-1:0][W-1:0] regs_flat;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     regs_q[b] <= '0;
      else if (we && wsel == IW'(b))  regs_q[b] <= wdata;
    end
    assign regs_flat[b] = regs_q[b];
  end

  assign rdata = (int'(rsel) < NB) ? regs_q[rsel] : '0;

  // R4: saved registers move only on a write
  p_bank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(regs_flat));

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int             AW       = 32,
  parameter logic [AW-1:0]  VEC_BASE = '0,
  parameter int             LINK_OFS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_rst,
  input  logic          req_und,
  input  logic          req_swi,
  input  logic          req_pabt,
  input  logic          req_dabt,
  input  logic          req_irq,
  input  logic          req_fiq,
  input  logic [AW-1:0] cur_pc,
  input  logic          ret_cmd,
  input  logic [AW-1:0] ret_addr,
  input  logic          sr_we,
  input  logic [SW-1:0] sr_wdata,
  output logic [SW-1:0] cpsr,
  output logic          pc_load,
  output logic [AW-1:0] pc_next,
  output logic          lr_we,
  output logic [4:0]    lr_mode,
  output logic [AW-1:0] lr_data,
  output logic          spsr_we,
  output logic [4:0]    spsr_mode,
  output logic [SW-1:0] spsr_data
);

  localparam int XIW = $clog2(NEXC);

  function automatic logic [AW-1:0] vec_addr(exc_e e);
    return VEC_BASE + (AW'(vector_slot(e)) << 2);
  endfunction

  logic [SW-1:0]   cpsr_q, cpsr_d;
  logic [NEXC-1:0] req_vec;
  logic            entry;
  logic [XIW-1:0]  win_idx;
  exc_e            win;
  mode_t           tgt_mode;
  mode_t           cur_mode;
  logic            ret_ok;
  logic [SW-1:0]   saved_st;

  always_comb begin
    req_vec = '0;
    req_vec[int'(EX_RST)]  = req_rst;
    req_vec[int'(EX_DABT)] = req_dabt;
    req_vec[int'(EX_FIQ)]  = req_fiq;
    req_vec[int'(EX_IRQ)]  = req_irq;
    req_vec[int'(EX_PABT)] = req_pabt;
    req_vec[int'(EX_UND)]  = req_und;
    req_vec[int'(EX_SWI)]  = req_swi;
  end

  exc_arbiter #(.N(NEXC)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req_vec),
    .mask_irq (cpsr_q[B_I]),
    .mask_fiq (cpsr_q[B_F]),
    .any      (entry),
    .idx      (win_idx)
  );

  assign win      = exc_e'(win_idx);
  assign tgt_mode = target_mode(win);
  assign cur_mode = cpsr_q[4:0];
  assign ret_ok   = ret_cmd && !entry && has_bank(cur_mode);

  exc_spsr_bank #(.NB(NBANK), .W(SW)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (entry),
    .wsel  (bank_idx(tgt_mode)),
    .wdata (cpsr_q),
    .rsel  (bank_idx(cur_mode)),
    .rdata (saved_st)
  );

  always_comb begin
    if (entry)       cpsr_d = entry_status(cpsr_q, win);
    else if (ret_ok) cpsr_d = saved_st;
    else if (sr_we)  cpsr_d = sr_wdata;
    else             cpsr_d = cpsr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpsr_q <= CPSR_RST;
    else        cpsr_q <= cpsr_d;
  end

  assign cpsr      = cpsr_q;
  assign pc_load   = entry || ret_ok;
  assign pc_next   = entry ? vec_addr(win) : (ret_ok ? ret_addr : '0);
  assign lr_we     = entry;
  assign lr_mode   = entry ? tgt_mode : 5'b0;
  assign lr_data   = entry ? cur_pc + AW'(LINK_OFS) : '0;
  assign spsr_we   = entry;
  assign spsr_mode = entry ? tgt_mode : 5'b0;
  assign spsr_data = entry ? cpsr_q : '0;

  // R3: the mode field lands on the accepted cause's mode
  p_entry_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> cpsr[4:0] == $past(tgt_mode));

  // R6: entry masks IRQ and leaves the 32-bit instruction state
  p_entry_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> (cpsr[B_I] && !cpsr[B_T]));

  // R6: flags survive entry
  p_entry_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> cpsr[31:28] == $past(cpsr[31:28]));

  // R9: return restores the saved word of the mode it leaves
  p_ret_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ok |=> cpsr == $past(saved_st));

  // R9: return from a mode without a saved register changes nothing
  p_ret_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_cmd && !entry && !sr_we && !has_bank(cpsr[4:0])) |=> $stable(cpsr));

  // R2: the reserved vector slot is never produced
  p_no_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
    entry |-> pc_next != VEC_BASE + AW'(20));

endmodule

// File: tb/exc_entry_ctrl_tb.sv
`timescale 1ns/100ps
module exc_entry_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_rst, req_und, req_swi, req_pabt, req_dabt, req_irq, req_fiq;
  logic [31:0] cur_pc, ret_addr, sr_wdata;
  logic        ret_cmd, sr_we;
  logic [31:0] cpsr, pc_next, lr_data, spsr_data;
  logic        pc_load, lr_we, spsr_we;
  logic [4:0]  lr_mode, spsr_mode;

  always #2.5 clk = ~clk;

  exc_entry_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_rst(req_rst), .req_und(req_und), .req_swi(req_swi),
    .req_pabt(req_pabt), .req_dabt(req_dabt), .req_irq(req_irq), .req_fiq(req_fiq),
    .cur_pc(cur_pc), .ret_cmd(ret_cmd), .ret_addr(ret_addr),
    .sr_we(sr_we), .sr_wdata(sr_wdata),
    .cpsr(cpsr), .pc_load(pc_load), .pc_next(pc_next),
    .lr_we(lr_we), .lr_mode(lr_mode), .lr_data(lr_data),
    .spsr_we(spsr_we), .spsr_mode(spsr_mode), .spsr_data(spsr_data)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // reference model state
  logic [31:0] m_cpsr;
  logic [31:0] m_saved [32];

  // cause codes used by the model
  localparam int C_NONE = -1, C_RST = 0, C_UND = 1, C_SWI = 2,
                 C_PABT = 3, C_DABT = 4, C_IRQ = 5, C_FIQ = 6;

  task automatic chk(string tag, string ctx, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s [%s] @%0t: got %h expected %h", tag, ctx, $time, act, exp);
    end
  endtask

  function automatic int pick_cause();
    if (req_rst)                    return C_RST;
    if (req_dabt)                   return C_DABT;
    if (req_fiq && !m_cpsr[6])      return C_FIQ;
    if (req_irq && !m_cpsr[7])      return C_IRQ;
    if (req_pabt)                   return C_PABT;
    if (req_und)                    return C_UND;
    if (req_swi)                    return C_SWI;
    return C_NONE;
  endfunction

  function automatic logic [31:0] vec_of(int c);
    case (c)
      C_RST:  return 32'h00;
      C_UND:  return 32'h04;
      C_SWI:  return 32'h08;
      C_PABT: return 32'h0C;
      C_DABT: return 32'h10;
      C_IRQ:  return 32'h18;
      default: return 32'h1C;
    endcase
  endfunction

  function automatic logic [4:0] mode_of(int c);
    case (c)
      C_RST, C_SWI:   return 5'b10011;
      C_PABT, C_DABT: return 5'b10111;
      C_UND:          return 5'b11011;
      C_IRQ:          return 5'b10010;
      default:        return 5'b10001;
    endcase
  endfunction

  function automatic bit banked(logic [4:0] m);
    return m == 5'b10001 || m == 5'b10010 || m == 5'b10011 ||
           m == 5'b10111 || m == 5'b11011;
  endfunction

  task automatic clear_in();
    {req_rst, req_und, req_swi, req_pabt, req_dabt, req_irq, req_fiq} = '0;
    ret_cmd = 1'b0; sr_we = 1'b0;
    cur_pc = 32'h4000_2000; ret_addr = 32'h0; sr_wdata = 32'h0;
  endtask

  // Called just after a falling edge with inputs applied: compare then advance model.
  task automatic step(string ctx);
    int c;
    logic [31:0] nx;
    bit rok;
    #1;
    c   = pick_cause();
    rok = (c == C_NONE) && ret_cmd && banked(m_cpsr[4:0]);
    chk("R6", ctx, cpsr, m_cpsr);
    chk("R2", ctx, {31'b0, pc_load}, {31'b0, (c != C_NONE) || rok});
    chk("R2", ctx, pc_next, (c != C_NONE) ? vec_of(c) : (rok ? ret_addr : 32'h0));
    chk("R5", ctx, {31'b0, lr_we}, {31'b0, c != C_NONE});
    chk("R5", ctx, lr_data, (c != C_NONE) ? cur_pc + 32'd4 : 32'h0);
    chk("R3", ctx, {27'b0, lr_mode}, {27'b0, (c != C_NONE) ? mode_of(c) : 5'b0});
    chk("R4", ctx, {31'b0, spsr_we}, {31'b0, c != C_NONE});
    chk("R4", ctx, spsr_data, (c != C_NONE) ? m_cpsr : 32'h0);
    chk("R3", ctx, {27'b0, spsr_mode}, {27'b0, (c != C_NONE) ? mode_of(c) : 5'b0});
    if (c != C_NONE) begin
      m_saved[mode_of(c)] = m_cpsr;
      nx = m_cpsr;
      nx[4:0] = mode_of(c);
      nx[7] = 1'b1;
      nx[5] = 1'b0;
      if (c == C_RST || c == C_FIQ) nx[6] = 1'b1;
      m_cpsr = nx;
    end else if (rok) begin
      m_cpsr = m_saved[m_cpsr[4:0]];
    end else if (sr_we) begin
      m_cpsr = sr_wdata;
    end
  endtask

  task automatic set_cause(int c);
    case (c)
      C_RST:  req_rst  = 1'b1;
      C_UND:  req_und  = 1'b1;
      C_SWI:  req_swi  = 1'b1;
      C_PABT: req_pabt = 1'b1;
      C_DABT: req_dabt = 1'b1;
      C_IRQ:  req_irq  = 1'b1;
      default: req_fiq = 1'b1;
    endcase
  endtask

  task automatic write_sr(logic [31:0] v, string ctx);
    @(negedge clk); clear_in(); sr_we = 1'b1; sr_wdata = v; step(ctx);
  endtask

  task automatic idle(string ctx);
    @(negedge clk); clear_in(); step(ctx);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) m_saved[i] = 32'h0;
    m_cpsr = 32'h0000_00D3;
    clear_in();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step("R1 reset state");
    idle("R1 reset idle");

    // every cause alone from user mode with masks open, then return
    for (int k = 0; k < 7; k++) begin
      write_sr({4'(k + 3), 20'h0, 8'h10}, "R10 status write");
      @(negedge clk); clear_in(); set_cause(k);
      cur_pc = 32'h4000_2004 + 32'(k * 16);
      step("R2 R3 R4 R5 single cause");
      idle("R6 entry status");
      @(negedge clk); clear_in(); ret_cmd = 1'b1; ret_addr = 32'h4000_2008 + 32'(k * 16);
      step("R9 return");
      idle("R9 restored status");
    end

    // priority with masks open
    write_sr(32'h5000_0010, "R7 open masks");
    @(negedge clk); clear_in();
    {req_rst, req_und, req_swi, req_pabt, req_dabt, req_irq, req_fiq} = '1;
    step("R7 all requests");
    for (int drop = 0; drop < 6; drop++) begin
      write_sr(32'h5000_0010, "R7 open masks");
      @(negedge clk); clear_in();
      {req_und, req_swi, req_pabt, req_dabt, req_irq, req_fiq} = '1;
      if (drop >= 1) req_dabt = 1'b0;
      if (drop >= 2) req_fiq  = 1'b0;
      if (drop >= 3) req_irq  = 1'b0;
      if (drop >= 4) req_pabt = 1'b0;
      if (drop >= 5) req_und  = 1'b0;
      step("R7 priority ladder");
    end

    // masking
    write_sr(32'h0000_0090, "R8 I set");
    @(negedge clk); clear_in(); req_irq = 1'b1; step("R8 IRQ masked");
    idle("R8 state after masked IRQ");
    write_sr(32'h0000_0050, "R8 F set");
    @(negedge clk); clear_in(); req_fiq = 1'b1; step("R8 FIQ masked");
    @(negedge clk); clear_in(); req_fiq = 1'b1; req_irq = 1'b1; step("R8 FIQ masked IRQ taken");
    idle("R8 after IRQ entry");

    // returns in modes without saved register
    write_sr(32'h2000_0010, "R9 user");
    @(negedge clk); clear_in(); ret_cmd = 1'b1; ret_addr = 32'h1234; step("R9 return in user ignored");
    write_sr(32'h2000_001F, "R9 system");
    @(negedge clk); clear_in(); ret_cmd = 1'b1; ret_addr = 32'h5678; step("R9 return in system ignored");
    idle("R9 system unchanged");

    // nesting: user -> svc -> und -> back
    write_sr(32'h9000_0010, "R4 nest start");
    @(negedge clk); clear_in(); req_swi = 1'b1; cur_pc = 32'h4000_3000; step("R4 nest swi");
    @(negedge clk); clear_in(); req_und = 1'b1; cur_pc = 32'h4000_1010; step("R4 nest und");
    @(negedge clk); clear_in(); ret_cmd = 1'b1; ret_addr = 32'h4000_1014; step("R9 nest leave und");
    @(negedge clk); clear_in(); ret_cmd = 1'b1; ret_addr = 32'h4000_3004; step("R9 nest leave svc");
    idle("R9 nest back in user");

    // collisions
    write_sr(32'h0000_0013, "R10 svc open");
    @(negedge clk); clear_in(); req_swi = 1'b1; ret_cmd = 1'b1; sr_we = 1'b1;
    sr_wdata = 32'hF000_0010; ret_addr = 32'hBEEF; step("R10 entry beats return and write");
    @(negedge clk); clear_in(); ret_cmd = 1'b1; ret_addr = 32'h4000_2008; sr_we = 1'b1;
    sr_wdata = 32'hF000_001F; step("R10 return beats write");
    idle("R10 after return");

    // random stretch
    for (int n = 0; n < 1500; n++) begin
      logic [4:0] modes [7];
      modes = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111};
      @(negedge clk); clear_in();
      req_rst  = ($urandom_range(0, 59) == 0);
      req_und  = ($urandom_range(0, 9) == 0);
      req_swi  = ($urandom_range(0, 9) == 0);
      req_pabt = ($urandom_range(0, 11) == 0);
      req_dabt = ($urandom_range(0, 11) == 0);
      req_irq  = ($urandom_range(0, 5) == 0);
      req_fiq  = ($urandom_range(0, 7) == 0);
      ret_cmd  = ($urandom_range(0, 4) == 0);
      sr_we    = ($urandom_range(0, 5) == 0);
      cur_pc   = {$urandom()} & 32'hFFFF_FFFC;
      ret_addr = {$urandom()} & 32'hFFFF_FFFC;
      sr_wdata = {4'($urandom()), 20'h0, 3'($urandom()), modes[$urandom_range(0, 6)]};
      step("R10 random mix");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule